// File: doc/BRIEF.md
# I2C Byte FIFO Request and Interrupt Unit

This block sits between the register port of an I2C controller and its shift engine. It holds one byte FIFO for transmit and one for receive. It counts the bytes still to move in the current transfer, and it raises the data-request events that software services. Each FIFO has a programmable threshold. A "ready" request asks software to move a burst of threshold size. A separate "draining" request covers the tail of a transfer, where the bytes left can never make up a full burst. In that case software moves only the remainder.

Besides the four data requests, the unit latches three bus events from the engine: transfer complete, missing acknowledge and lost arbitration. All seven events sit in one sticky status register that software clears by writing ones. They are masked by an enable register, which has separate set and clear addresses, and they drive a single interrupt line. Software fills the transmit FIFO and empties the receive FIFO through one data address. The engine pops transmit bytes and pushes receive bytes directly.

Top module: `i2c_fifo_irq`

## Requirements
- R1: After reset the status, enable, threshold codes, remaining count and both FIFO levels read zero, and `irq` is low.
- R2: The configuration register (address 0) holds the transmit threshold code in bits [5:0] and the receive threshold code in bits [13:8]. Each threshold equals its code plus one. Reads return the codes, with bits 6, 7, 14 and 15 reading zero.
- R3: In a transmit transfer, status bit 0 (tx ready) sets when the transmit level is below the threshold and the bytes software must still supply (remaining count minus level) are at least the threshold.
- R4: In a transmit transfer, status bit 1 (tx draining) sets when the level is below the threshold and the bytes still to supply are non-zero but below the threshold. Bits 0 and 1 are never both set, and draining clears a pending tx ready.
- R5: In a receive transfer, status bit 2 (rx ready) sets when the receive level is at least the receive threshold.
- R6: In a receive transfer, status bit 3 (rx draining) sets when the remaining count is zero and the receive level is non-zero but below the threshold. Bits 2 and 3 are never both set, and draining clears a pending rx ready.
- R7: Pulses on `ev_done`, `ev_nack` and `ev_arb` set status bits 4, 5 and 6.
- R8: Writing the status register (address 1) clears each bit written as one and leaves bits written as zero unchanged. A value of 0xFFFF clears all bits. A set in the same cycle wins over the clear.
- R9: Writing address 2 sets enable bits and writing address 3 clears them, with both addresses reading the enables. `irq` is high exactly when a status bit and its enable bit are both set.
- R10: Writing one to configuration bit 6 empties the transmit FIFO, and writing one to bit 14 empties the receive FIFO.
- R11: Address 7 bits [2:0] report log2(DEPTH/8), so the FIFO depth is 8 shifted left by that field.
- R12: `xfer_start` loads the remaining count from the count register (address 4, write). The remaining count then decrements, never below zero, for each byte popped by the engine from a non-empty transmit FIFO and for each byte the engine pushes. Address 4 reads the remaining count.
- R13: Writes to address 5 push the transmit FIFO and reads of address 5 pop the receive FIFO, both in first-in first-out order. A push to a full FIFO is dropped. Address 6 reads the transmit level in [7:0] and the receive level in [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive FIFO at address 5) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| xfer_start | input | 1 | Start of a transfer: loads the remaining count |
| xfer_tx | input | 1 | Direction sampled at start: 1 transmit, 0 receive |
| tx_pop | input | 1 | Engine takes the head transmit byte |
| tx_byte | output | 8 | Head of the transmit FIFO |
| tx_avail | output | 1 | Transmit FIFO not empty |
| rx_push | input | 1 | Engine delivers a received byte |
| rx_byte | input | 8 | Received byte |
| ev_done | input | 1 | Transfer complete event |
| ev_nack | input | 1 | Missing acknowledge event |
| ev_arb | input | 1 | Arbitration lost event |
| irq | output | 1 | Masked interrupt request |

## Verification
Register reads and `tx_byte` are combinational, so they reflect state on the same cycle. A register write, push or pop changes FIFO levels and the remaining count at the next rising edge. A request status bit, which depends on those levels, appears one edge later still, and `irq` follows the status bit with no further delay. The bench drives every stimulus on a falling edge. It then waits three full cycles after the last stimulus before it reads status, and it samples just after a falling edge. Every result is therefore due before it is read, and no check depends on the order of events at a clock edge.

// File: rtl/i2c_fifo_irq_pkg.sv
package i2c_fifo_irq_pkg;

   localparam int unsigned REG_AW  = 3;
   localparam int unsigned REG_DW  = 16;
   localparam int unsigned BYTE_W  = 8;
   localparam int unsigned CODE_W  = 6;
   localparam int unsigned THR_W   = CODE_W + 1;
   localparam int unsigned EVT_N   = 7;

   localparam logic [REG_AW-1:0] A_CFG   = 3'd0;
   localparam logic [REG_AW-1:0] A_EVT   = 3'd1;
   localparam logic [REG_AW-1:0] A_MSET  = 3'd2;
   localparam logic [REG_AW-1:0] A_MCLR  = 3'd3;
   localparam logic [REG_AW-1:0] A_COUNT = 3'd4;
   localparam logic [REG_AW-1:0] A_DATA  = 3'd5;
   localparam logic [REG_AW-1:0] A_LEVEL = 3'd6;
   localparam logic [REG_AW-1:0] A_INFO  = 3'd7;

   localparam int unsigned B_TXREQ = 0;
   localparam int unsigned B_TXDR  = 1;
   localparam int unsigned B_RXREQ = 2;
   localparam int unsigned B_RXDR  = 3;

   localparam int unsigned CFG_TXCLR = 6;
   localparam int unsigned CFG_RXCLR = 14;

   // bit 0 is the last member
   typedef struct packed {
      logic arb;
      logic nack;
      logic done;
      logic rx_drain;
      logic rx_req;
      logic tx_drain;
      logic tx_req;
   } evt_t;

endpackage

// File: rtl/ififo_buf.sv
module ififo_buf #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned W     = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         push,
   input  logic [W-1:0]                 din,
   input  logic                         pop,
   output logic [W-1:0]                 dout,
   output logic [$clog2(DEPTH+1)-1:0]   level,
   output logic                         empty,
   output logic                         full
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned LW = $clog2(DEPTH+1);

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [LW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == LW'(DEPTH));
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp_q];
   assign level   = cnt_q;

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp_q] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + 1'b1;
         if (do_pop)  rp_q <= rp_q + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/ififo_reqgen.sv
module ififo_reqgen #(
   parameter bit          IS_TX = 1'b1,
   parameter int unsigned LVL_W = 5,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned THR_W = 7
) (
   input  logic             active,
   input  logic [LVL_W-1:0] level,
   input  logic [THR_W-1:0] thr,
   input  logic [CNT_W-1:0] rem,
   output logic             ready_c,
   output logic             drain_c
);
   logic [CNT_W-1:0] lvl_x, thr_x;
   logic             below;

   assign lvl_x = CNT_W'(level);
   assign thr_x = CNT_W'(thr);
   assign below = (lvl_x < thr_x);

   generate
      if (IS_TX) begin : g_tx
         logic [CNT_W-1:0] need;
         always_comb need = (rem > lvl_x) ? (rem - lvl_x) : '0;
         assign ready_c = active && below && (need >= thr_x);
         assign drain_c = active && below && (need != '0) && (need < thr_x);
      end else begin : g_rx
         assign ready_c = active && !below;
         assign drain_c = active && below && (lvl_x != '0) && (rem == '0);
      end
   endgenerate
endmodule

// File: rtl/ififo_evtreg.sv
module ififo_evtreg
   import i2c_fifo_irq_pkg::*;
#(
   parameter int unsigned N = EVT_N
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] w1c,
   input  logic [N-1:0] en_set,
   input  logic [N-1:0] en_clr,
   output logic [N-1:0] evt_q,
   output logic [N-1:0] en_q,
   output logic         irq
);
   logic [N-1:0] nxt;

   always_comb begin
      nxt = (evt_q & ~w1c) | set;
      // a pending tail request displaces the burst request of its FIFO
      if (nxt[B_TXDR]) nxt[B_TXREQ] = 1'b0;
      if (nxt[B_RXDR]) nxt[B_RXREQ] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         evt_q <= '0;
         en_q  <= '0;
      end else begin
         evt_q <= nxt;
         en_q  <= (en_q | en_set) & ~en_clr;
      end
   end

   assign irq = |(evt_q & en_q);
endmodule

// File: rtl/i2c_fifo_irq.sv
module i2c_fifo_irq
   import i2c_fifo_irq_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              xfer_start,
   input  logic              xfer_tx,
   input  logic              tx_pop,
   output logic [7:0]        tx_byte,
   output logic              tx_avail,
   input  logic              rx_push,
   input  logic [7:0]        rx_byte,
   input  logic              ev_done,
   input  logic              ev_nack,
   input  logic              ev_arb,
   output logic              irq
);
   localparam int unsigned LVL_W = $clog2(DEPTH+1);
   localparam int unsigned DCODE = $clog2(DEPTH/8);

   generate
      if (DEPTH < 8 || DEPTH > 64 || (DEPTH & (DEPTH-1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two from 8 to 64");
      end
      if (CNT_W < THR_W || CNT_W > REG_DW) begin : g_bad_cnt
         $error("CNT_W must lie between 7 and 16");
      end
   endgenerate

   // ---------------- register decode
   logic wr_cfg, wr_evt, wr_mset, wr_mclr, wr_cnt, wr_data, rd_data;
   assign wr_cfg  = reg_wr && (reg_addr == A_CFG);
   assign wr_evt  = reg_wr && (reg_addr == A_EVT);
   assign wr_mset = reg_wr && (reg_addr == A_MSET);
   assign wr_mclr = reg_wr && (reg_addr == A_MCLR);
   assign wr_cnt  = reg_wr && (reg_addr == A_COUNT);
   assign wr_data = reg_wr && (reg_addr == A_DATA);
   assign rd_data = reg_rd && (reg_addr == A_DATA);

   // ---------------- configuration and transfer state
   logic [CODE_W-1:0] tx_code_q, rx_code_q;
   logic [CNT_W-1:0]  cnt_q, rem_q;
   logic              is_tx_q;
   logic              moved;
   logic              tx_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_code_q <= '0;
         rx_code_q <= '0;
         cnt_q     <= '0;
      end else begin
         if (wr_cfg) begin
            tx_code_q <= reg_wdata[CODE_W-1:0];
            rx_code_q <= reg_wdata[8 +: CODE_W];
         end
         if (wr_cnt) cnt_q <= reg_wdata[CNT_W-1:0];
      end
   end

   assign moved = (tx_pop && !tx_empty) || rx_push;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q   <= '0;
         is_tx_q <= 1'b0;
      end else if (xfer_start) begin
         rem_q   <= cnt_q;
         is_tx_q <= xfer_tx;
      end else if (moved && rem_q != '0) begin
         rem_q   <= rem_q - 1'b1;
      end
   end

   // ---------------- byte FIFOs
   logic [LVL_W-1:0]  tx_level, rx_level;
   logic [BYTE_W-1:0] rx_head;
   logic              tx_full, rx_empty, rx_full;

   ififo_buf #(.DEPTH(DEPTH), .W(BYTE_W)) u_txf (
      .clk(clk), .rst_n(rst_n), .clr(wr_cfg && reg_wdata[CFG_TXCLR]),
      .push(wr_data), .din(reg_wdata[BYTE_W-1:0]), .pop(tx_pop),
      .dout(tx_byte), .level(tx_level), .empty(tx_empty), .full(tx_full));

   ififo_buf #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxf (
      .clk(clk), .rst_n(rst_n), .clr(wr_cfg && reg_wdata[CFG_RXCLR]),
      .push(rx_push), .din(rx_byte), .pop(rd_data),
      .dout(rx_head), .level(rx_level), .empty(rx_empty), .full(rx_full));

   assign tx_avail = !tx_empty;

   // ---------------- request conditions
   logic [THR_W-1:0] tx_thr, rx_thr;
   logic             txr_c, txd_c, rxr_c, rxd_c;

   assign tx_thr = {1'b0, tx_code_q} + 1'b1;
   assign rx_thr = {1'b0, rx_code_q} + 1'b1;

   ififo_reqgen #(.IS_TX(1'b1), .LVL_W(LVL_W), .CNT_W(CNT_W), .THR_W(THR_W)) u_txreq (
      .active(is_tx_q), .level(tx_level), .thr(tx_thr), .rem(rem_q),
      .ready_c(txr_c), .drain_c(txd_c));

   ififo_reqgen #(.IS_TX(1'b0), .LVL_W(LVL_W), .CNT_W(CNT_W), .THR_W(THR_W)) u_rxreq (
      .active(!is_tx_q), .level(rx_level), .thr(rx_thr), .rem(rem_q),
      .ready_c(rxr_c), .drain_c(rxd_c));

   // ---------------- status, enables, interrupt
   evt_t             ev_set;
   logic [EVT_N-1:0] evt_q, en_q;

   always_comb begin
      ev_set.tx_req   = txr_c;
      ev_set.tx_drain = txd_c;
      ev_set.rx_req   = rxr_c;
      ev_set.rx_drain = rxd_c;
      ev_set.done     = ev_done;
      ev_set.nack     = ev_nack;
      ev_set.arb      = ev_arb;
   end

   ififo_evtreg #(.N(EVT_N)) u_evt (
      .clk(clk), .rst_n(rst_n), .set(ev_set),
      .w1c   (wr_evt  ? reg_wdata[EVT_N-1:0] : '0),
      .en_set(wr_mset ? reg_wdata[EVT_N-1:0] : '0),
      .en_clr(wr_mclr ? reg_wdata[EVT_N-1:0] : '0),
      .evt_q(evt_q), .en_q(en_q), .irq(irq));

   // ---------------- read mux
   always_comb begin
      case (reg_addr)
         A_CFG:          reg_rdata = {2'b00, rx_code_q, 2'b00, tx_code_q};
         A_EVT:          reg_rdata = REG_DW'(evt_q);
         A_MSET, A_MCLR: reg_rdata = REG_DW'(en_q);
         A_COUNT:        reg_rdata = REG_DW'(rem_q);
         A_DATA:         reg_rdata = REG_DW'(rx_head);
         A_LEVEL:        reg_rdata = {8'(rx_level), 8'(tx_level)};
         default:        reg_rdata = REG_DW'(DCODE);
      endcase
   end

   logic unused_ok;
   assign unused_ok = ^{tx_full, rx_empty, rx_full, reg_wdata};
endmodule

// File: rtl/i2c_fifo_irq_chk.sv
module i2c_fifo_irq_chk
   import i2c_fifo_irq_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned CNT_W = 16,
   parameter int unsigned LVL_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [2:0]       reg_addr,
   input logic             reg_wr,
   input logic [15:0]      reg_wdata,
   input logic             xfer_start,
   input logic             ev_done,
   input logic             ev_nack,
   input logic             ev_arb,
   input logic             irq,
   input logic [EVT_N-1:0] evt,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] rem,
   input logic [LVL_W-1:0] tx_level
);
   AST_TX_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt[B_TXREQ] && evt[B_TXDR]));                                     // R4
   AST_RX_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !(evt[B_RXREQ] && evt[B_RXDR]));                                     // R6
   AST_DONE_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
      ev_done |=> evt[4]);                                                 // R7
   AST_W1C_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_EVT && reg_wdata[6:0] == 7'h7f
       && !ev_done && !ev_nack && !ev_arb) |=> (evt[6:4] == 3'b000));      // R8
   AST_MASK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_MCLR && reg_wdata[6:0] == 7'h7f) |=> !irq); // R9
   AST_TX_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_CFG && reg_wdata[CFG_TXCLR]) |=> (tx_level == '0)); // R10
   AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> (rem == $past(cnt_q)));                               // R12
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tx_level <= LVL_W'(DEPTH));                                          // R13
endmodule

bind i2c_fifo_irq i2c_fifo_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_wdata(reg_wdata), .xfer_start(xfer_start), .ev_done(ev_done),
   .ev_nack(ev_nack), .ev_arb(ev_arb), .irq(irq), .evt(evt_q),
   .cnt_q(cnt_q), .rem(rem_q), .tx_level(tx_level));

// File: tb/i2c_fifo_irq_bench.sv
module i2c_fifo_irq_bench;
   import i2c_fifo_irq_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        xfer_start = 1'b0, xfer_tx = 1'b0;
   logic        tx_pop = 1'b0, rx_push = 1'b0;
   logic [7:0]  tx_byte, rx_byte = '0;
   logic        tx_avail;
   logic        ev_done = 1'b0, ev_nack = 1'b0, ev_arb = 1'b0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   i2c_fifo_irq u_i2c_fifo_irq (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .xfer_start(xfer_start), .xfer_tx(xfer_tx), .tx_pop(tx_pop),
      .tx_byte(tx_byte), .tx_avail(tx_avail), .rx_push(rx_push),
      .rx_byte(rx_byte), .ev_done(ev_done), .ev_nack(ev_nack),
      .ev_arb(ev_arb), .irq(irq));

   // {threshold, count, bytes written, expected status[1:0]}
   localparam int NVEC = 7;
   localparam logic [31:0] VEC [NVEC] = '{
      32'h04_0A_00_01, 32'h04_03_00_02, 32'h04_0A_05_00, 32'h04_06_03_02,
      32'h01_02_00_01, 32'h08_08_00_01, 32'h04_03_03_00 };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pop_rx(output logic [7:0] d);
      @(negedge clk);
      reg_addr = A_DATA; reg_rd = 1'b1;
      #1 d = reg_rdata[7:0];
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pop_tx(output logic [7:0] d);
      @(negedge clk);
      d = tx_byte; tx_pop = 1'b1;
      @(negedge clk);
      tx_pop = 1'b0;
   endtask

   task automatic push_rx(input logic [7:0] b);
      @(negedge clk);
      rx_byte = b; rx_push = 1'b1;
      @(negedge clk);
      rx_push = 1'b0;
   endtask

   task automatic start(input logic dir_tx);
      @(negedge clk);
      xfer_tx = dir_tx; xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
   endtask

   task automatic report;
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      report();
   end

   initial begin
      logic [15:0] rv;
      logic [7:0]  b;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(A_EVT, rv);   chk("R1 status", rv, 0);
      rd(A_MSET, rv);  chk("R1 enables", rv, 0);
      rd(A_CFG, rv);   chk("R1 cfg", rv, 0);
      rd(A_LEVEL, rv); chk("R1 levels", rv, 0);
      rd(A_COUNT, rv); chk("R1 count", rv, 0);
      chk("R1 irq", irq, 0);
      // R11 depth code for 16 bytes
      rd(A_INFO, rv);  chk("R11 depth code", rv[2:0], 1);

      // R3/R4 vector table (transmit)
      for (int i = 0; i < NVEC; i++) begin
         wr(A_CFG, 16'h0040 | 16'(VEC[i][31:24] - 8'd1));
         wr(A_COUNT, 16'(VEC[i][23:16]));
         start(1'b1);
         for (int k = 0; k < int'(VEC[i][15:8]); k++) wr(A_DATA, 16'(8'h30 + k));
         wr(A_EVT, 16'hFFFF);
         idle(3);
         rd(A_EVT, rv);
         chk($sformatf("R3/R4 vec %0d tx bits", i), rv[1:0], VEC[i][1:0]);
      end

      // R4 priority: draining displaces a pending ready
      wr(A_CFG, 16'h0043);
      wr(A_COUNT, 16'd6);
      start(1'b1);
      wr(A_EVT, 16'h007F);
      idle(3);
      rd(A_EVT, rv); chk("R3 ready before data", rv[1:0], 2'b01);
      for (int k = 0; k < 3; k++) wr(A_DATA, 16'h00A0);
      idle(3);
      rd(A_EVT, rv); chk("R4 drain replaces ready", rv[1:0], 2'b10);

      // R2 threshold readback, clear bits not stored
      wr(A_CFG, 16'h4545);
      rd(A_CFG, rv); chk("R2 cfg readback", rv, 16'h0505);

      // R12/R13 transmit order and counting
      wr(A_CFG, 16'h0043);
      wr(A_COUNT, 16'd5);
      start(1'b1);
      wr(A_DATA, 16'h0011);
      wr(A_DATA, 16'h0022);
      pop_tx(b); chk("R13 tx first", b, 8'h11);
      pop_tx(b); chk("R13 tx second", b, 8'h22);
      rd(A_COUNT, rv); chk("R12 count after pops", rv, 3);
      chk("R13 tx empty", tx_avail, 0);
      pop_tx(b);
      rd(A_COUNT, rv); chk("R12 empty pop ignored", rv, 3);

      // R13 overflow and R10 flush
      wr(A_CFG, 16'h0040);
      for (int k = 0; k < 17; k++) wr(A_DATA, 16'(k));
      rd(A_LEVEL, rv); chk("R13 full level", rv[7:0], 16);
      wr(A_CFG, 16'h0040);
      rd(A_LEVEL, rv); chk("R10 tx flushed", rv[7:0], 0);

      // R5/R6 receive
      wr(A_CFG, 16'h4240);
      wr(A_COUNT, 16'd4);
      start(1'b0);
      wr(A_EVT, 16'h007F);
      push_rx(8'hA1); push_rx(8'hB2); push_rx(8'hC3);
      idle(3);
      rd(A_EVT, rv);   chk("R5 rx ready", rv, 16'h0004);
      rd(A_LEVEL, rv); chk("R13 rx level", rv, 16'h0300);
      rd(A_COUNT, rv); chk("R12 rx count", rv, 1);
      pop_rx(b); chk("R13 rx first", b, 8'hA1);
      pop_rx(b); chk("R13 rx second", b, 8'hB2);
      pop_rx(b); chk("R13 rx third", b, 8'hC3);
      wr(A_EVT, 16'h007F);
      push_rx(8'hD4);
      idle(3);
      rd(A_EVT, rv); chk("R6 rx drain", rv, 16'h0008);

      // R6 priority
      wr(A_CFG, 16'h4200);
      wr(A_COUNT, 16'd3);
      start(1'b0);
      wr(A_EVT, 16'h007F);
      push_rx(8'h01); push_rx(8'h02); push_rx(8'h03);
      idle(3);
      rd(A_EVT, rv); chk("R5 ready at threshold", rv, 16'h0004);
      pop_rx(b);
      idle(3);
      rd(A_EVT, rv); chk("R6 drain replaces ready", rv, 16'h0008);

      // R12 saturation, R10 rx flush
      wr(A_CFG, 16'h4200);
      wr(A_COUNT, 16'd1);
      start(1'b0);
      push_rx(8'h05); push_rx(8'h06);
      rd(A_COUNT, rv); chk("R12 saturates at zero", rv, 0);
      wr(A_CFG, 16'h4000);
      rd(A_LEVEL, rv); chk("R10 rx flushed", rv[15:8], 0);

      // R7/R8/R9 events, clearing, masking
      wr(A_COUNT, 16'd5);
      start(1'b0);
      wr(A_EVT, 16'hFFFF);
      wr(A_MSET, 16'h0010);
      @(negedge clk); ev_done = 1'b1; @(negedge clk); ev_done = 1'b0;
      rd(A_EVT, rv); chk("R7 done bit", rv, 16'h0010);
      chk("R9 irq on enabled", irq, 1);
      @(negedge clk); ev_nack = 1'b1; @(negedge clk); ev_nack = 1'b0;
      rd(A_EVT, rv); chk("R7 nack bit", rv, 16'h0030);
      wr(A_MCLR, 16'h0010);
      chk("R9 irq masked", irq, 0);
      wr(A_MSET, 16'h0020);
      rd(A_MCLR, rv); chk("R9 enable readback", rv, 16'h0020);
      chk("R9 irq nack enabled", irq, 1);
      wr(A_EVT, 16'h0000);
      rd(A_EVT, rv); chk("R8 zero write no effect", rv, 16'h0030);
      wr(A_EVT, 16'h0010);
      rd(A_EVT, rv); chk("R8 single clear", rv, 16'h0020);
      @(negedge clk);
      reg_addr = A_EVT; reg_wdata = 16'h0040; reg_wr = 1'b1; ev_arb = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; ev_arb = 1'b0;
      rd(A_EVT, rv); chk("R8 set wins over clear", rv, 16'h0060);
      wr(A_EVT, 16'hFFFF);
      rd(A_EVT, rv); chk("R8 clear all", rv, 0);
      chk("R9 irq low after clear", irq, 0);

      report();
   end
endmodule